// File: doc/BRIEF.md
# Shaped Amplitude Envelope Generator

This block produces one amplitude level, 5 bits wide, that several voices of a tone generator share. The level moves along a ramp at a rate set by a 16-bit period. The ramp is either rising or falling, and it can run once, repeat as a sawtooth, repeat as a triangle, or stop and hold. A 4-bit shape code selects the pattern. The level can move in 32 fine steps or in 16 coarse steps. Both resolutions cover the full 0 to 31 range.

Time advances only on the input enable. A built-in prescaler divides the enable by 8 to form a core tick. A period divider then counts core ticks. A one-cycle restart pulse clears the prescaler, the period divider and the step position together, so the new shape starts from its first step. Register access, per-voice volume selection and the volume tables sit outside this block.

Top module: `env_shaper`

## Requirements
- R1: After reset the shape code is taken as 0, the level is 31, and the level holds there until the first step.
- R2: With the enable held high, the level takes its k-th step exactly 8*P*k clock edges after the restart edge, where P is the period. The restart edge is the rising edge that samples the restart pulse.
- R3: A period of 0 gives the same step timing as a period of 1.
- R4: In fine mode (fine_steps = 1) a rising ramp gives level = step index (0..31), and a falling ramp gives 31 minus the index.
- R5: In coarse mode (fine_steps = 0) the ramp position r (0..15) maps to level = 2*r + (r >= 8 ? 1 : 0). The range is therefore 0 to 31, and level bit 0 always equals level bit 4.
- R6: The shape bit positions are: shape[3] = continue, shape[2] = attack (1 rises from 0, 0 falls from 31), shape[1] = alternate, shape[0] = hold. With continue = 0 the level drops to 0 after the first ramp and stays at 0.
- R7: With continue = 1 and hold = 1, the level stays after the first ramp at the value where that ramp ended (31 if rising, 0 if falling). If alternate is also set, it stays at the opposite extreme instead.
- R8: With continue = 1 and hold = 0, the ramp repeats with no end. Without alternate every ramp has the same direction. With alternate the direction reverses on each ramp.
- R9: A restart pulse, at any point of a sequence, puts the level at its first step in the next cycle: 0 if attack is set, 31 if not. Timing then restarts from zero as in R2.
- R10: While the enable is low, the level does not change, as long as no restart occurs and the shape and mode inputs stay constant. Cycles with the enable low delay every later step by the same number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Time-base enable; 8 enabled cycles make one core tick |
| fine_steps | input | 1 | 1 = 32-step ramps, 0 = 16-step ramps |
| restart | input | 1 | One-cycle pulse that restarts the sequence (issued when a shape is written) |
| shape | input | 4 | Shape code: continue, attack, alternate, hold (bit 3 to bit 0) |
| period | input | 16 | Core ticks per step; 0 acts as 1 |
| level | output | 5 | Envelope level |

## Verification
The level is decoded combinationally from the state registers. A step that lands on rising edge c0 + 8*P*k is therefore visible in the cycle that follows that edge, and it holds until the next step. Here c0 is the restart edge. The bench counts rising edges. It schedules each expected level against the edge count at which it is due, with k steps and any enable-low gap of G cycles adding G to every due count. It compares on the falling edge of exactly that cycle. An item whose due count has passed without a comparison is reported as a failure, so a step that comes early or late cannot go unnoticed.

// File: rtl/env_shaper.sv
module env_shaper #(
  parameter int PER_W   = 16,
  parameter int LVL_W   = 5,
  parameter int PRE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fine_steps,
  input  logic             restart,
  input  logic [3:0]       shape,
  input  logic [PER_W-1:0] period,
  output logic [LVL_W-1:0] level
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [LVL_W-1:0] TOP_FINE   = '1;
  localparam logic [LVL_W-1:0] TOP_COARSE = {1'b0, {(LVL_W-1){1'b1}}};

  logic [PRE_W-1:0] pre_q;
  logic [PER_W-1:0] per_q;
  logic [LVL_W-1:0] idx_q;
  logic             flip_q;
  logic             done_q;
  logic             held_hi_q;

  logic             tick, step, ramp_end, up;
  logic [PER_W-1:0] per_lim;
  logic [LVL_W-1:0] idx_top, raw, ramp_lvl;

  assign tick     = en && (pre_q == PRE_LAST);
  assign per_lim  = (period == '0) ? PER_W'(1) : period;
  assign step     = tick && (per_q >= per_lim - PER_W'(1));
  assign idx_top  = fine_steps ? TOP_FINE : TOP_COARSE;
  assign ramp_end = idx_q >= idx_top;
  assign up       = shape[2] ^ flip_q;
  assign raw      = up ? idx_q : idx_top - idx_q;
  assign ramp_lvl = fine_steps ? raw : {raw[LVL_W-2:0], raw[LVL_W-2]};
  assign level    = done_q ? {LVL_W{held_hi_q}} : ramp_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      per_q     <= '0;
      idx_q     <= '0;
      flip_q    <= 1'b0;
      done_q    <= 1'b0;
      held_hi_q <= 1'b0;
    end else if (restart) begin
      pre_q     <= '0;
      per_q     <= '0;
      idx_q     <= '0;
      flip_q    <= 1'b0;
      done_q    <= 1'b0;
      held_hi_q <= 1'b0;
    end else begin
      if (en)
        pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick)
        per_q <= step ? '0 : per_q + PER_W'(1);
      if (step && !done_q) begin
        if (ramp_end) begin
          idx_q <= '0;
          if (!shape[3]) begin
            done_q    <= 1'b1;
            held_hi_q <= 1'b0;
          end else if (shape[0]) begin
            done_q    <= 1'b1;
            held_hi_q <= shape[2] ^ shape[1];
          end else begin
            flip_q <= flip_q ^ shape[1];
          end
        end else begin
          idx_q <= idx_q + LVL_W'(1);
        end
      end
    end
  end
endmodule

module env_shaper_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             restart,
  input logic             fine_steps,
  input logic [3:0]       shape,
  input logic [LVL_W-1:0] level,
  input logic             done_q,
  input logic             held_hi_q
);
  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en) && !$past(restart) && $stable(shape) && $stable(fine_steps)) |-> $stable(level));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!$stable(shape) || level == (shape[2] ? {LVL_W{1'b0}} : {LVL_W{1'b1}})));

  // R6
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !shape[3]) |-> (level == '0 && !held_hi_q));

  // R7
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && shape[3] && shape[0] && $stable(shape))
      |-> level == ((shape[2] ^ shape[1]) ? {LVL_W{1'b1}} : {LVL_W{1'b0}}));

  // R5
  coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_steps |-> (level[0] == level[LVL_W-1]));
endmodule

bind env_shaper env_shaper_chk #(.LVL_W(LVL_W)) u_env_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .restart(restart), .fine_steps(fine_steps),
  .shape(shape), .level(level), .done_q(done_q), .held_hi_q(held_hi_q)
);

// File: tb/test_env_shaper.sv
`timescale 1ns/1ps
module test_env_shaper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        fine_steps = 1'b1;
  logic        restart = 1'b0;
  logic [3:0]  shape = 4'd0;
  logic [15:0] period = 16'd1;
  logic [4:0]  level;

  typedef struct { int at; int val; string req; } item_t;
  item_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit over = 0;

  env_shaper i_env_shaper (
    .clk(clk), .rst_n(rst_n), .en(en), .fine_steps(fine_steps),
    .restart(restart), .shape(shape), .period(period), .level(level)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model(bit [3:0] sh, bit fine, int k);
    int n = fine ? 32 : 16;
    int r = k / n;
    int i = k % n;
    int raw;
    bit up;
    if (k >= n && !sh[3]) return 0;
    if (k >= n && sh[0]) return (sh[2] ^ sh[1]) ? 31 : 0;
    up  = sh[2] ^ (sh[1] & r[0]);
    raw = up ? i : n - 1 - i;
    return fine ? raw : raw * 2 + ((raw >= 8) ? 1 : 0);
  endfunction

  task automatic note(string req, int act, int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s: level=%0d expected=%0d (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at < cyc) begin
      total++; bad++;
      $display("FAIL %s: result missed, due cycle %0d expected=%0d actual=none", q[0].req, q[0].at, q[0].val);
      void'(q.pop_front());
    end
    if (q.size() > 0 && q[0].at == cyc) begin
      note(q[0].req, int'(level), q[0].val);
      void'(q.pop_front());
    end
  end

  task automatic run(bit [3:0] sh, bit fine, int per, int steps, int gap, string req);
    int c0;
    int p_eff = (per == 0) ? 1 : per;
    @(negedge clk);
    shape = sh; fine_steps = fine; period = 16'(per);
    restart = 1'b1; en = (gap == 0);
    @(posedge clk); #1;
    c0 = cyc;
    restart = 1'b0;
    if (gap > 0) begin
      q.push_back('{at: c0 + 1, val: model(sh, fine, 0), req: req});
      q.push_back('{at: c0 + gap - 1, val: model(sh, fine, 0), req: req});
    end
    for (int k = 0; k <= steps; k++) begin
      q.push_back('{at: c0 + gap + 8 * p_eff * k, val: model(sh, fine, k), req: req});
      if (k > 0)
        q.push_back('{at: c0 + gap + 8 * p_eff * k - 1, val: model(sh, fine, k - 1), req: req});
    end
    q.sort() with (item.at);
    if (gap > 0) begin
      repeat (gap) @(posedge clk);
      #1 en = 1'b1;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    over = 1;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    note("R1", int'(level), 31);
    repeat (20) @(negedge clk);
    note("R1", int'(level), 31);
    run(4'b0100, 1'b1, 1, 34, 0, "R4 R6 R2");
    run(4'b0000, 1'b1, 2, 34, 0, "R4 R6 R2");
    run(4'b0100, 1'b0, 2, 18, 0, "R5 R6");
    run(4'b1000, 1'b1, 0, 70, 0, "R3 R8");
    run(4'b1110, 1'b0, 1, 50, 0, "R8 R5");
    run(4'b1100, 1'b0, 1, 36, 0, "R8");
    run(4'b1101, 1'b1, 1, 36, 0, "R7");
    run(4'b1111, 1'b1, 1, 36, 0, "R7");
    run(4'b1011, 1'b0, 1, 20, 0, "R7");
    run(4'b1100, 1'b1, 3, 5, 0, "R9");
    repeat (11) @(negedge clk);
    run(4'b1000, 1'b1, 3, 4, 0, "R9");
    repeat (5) @(negedge clk);
    run(4'b1100, 1'b1, 1, 6, 100, "R10");
    if (!over) $display("test done: total=%0d bad=%0d", total, bad);
    else $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (over);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule